// File: doc/BRIEF.md
# Sleep Control Register Decoder

This block holds the 16-bit power-management control word that system software uses to choose a sleep state. The word sits at byte offset 4 of a small register window. Only 16-bit accesses are honoured, and the data is little-endian, so `acc_wdata[7:0]` is the byte at offset 4 and `acc_wdata[15:8]` is the byte at offset 5. Bit 13 is a command bit, called sleep-go here. Writing it starts a transition to sleep. The block acts on it but never stores it.

When a write carries sleep-go, the 3-bit sleep-type field in bits 12:10 is decoded into request pulses. Each pulse lasts one clock cycle and comes one cycle after the write:
- Type 0 is a soft power-off.
- Type 1 is suspend-to-RAM.
- Any other type is treated as suspend-to-disk, but only when it equals the value on the `cfg_s4_type` configuration input. A disk request sends a notification pulse and a power-off pulse together.
- Any other type that does not match produces nothing.

Bit 0 is the interrupt-routing enable. Platform logic can force it high or low through two side inputs.

Top module: `sleepctl_top`

## Requirements
- R1: An accepted write stores the written value with bit 13 (sleep-go) cleared. An accepted read returns the stored word, so bit 13 always reads as 0.
- R2: An access is accepted only if `acc_valid` is high, `acc_addr` equals 4 and `acc_size` is 1 (the 16-bit code; 0 means 8-bit and 2 means 32-bit). Any other write leaves the stored word unchanged. Any other read returns 0.
- R3: A request output is high only in the cycle after an accepted write that had bit 13 set. Each such write gives exactly one cycle of request.
- R4: An accepted write with bit 13 set and bits 12:10 equal to 0 pulses `poweroff_req` alone.
- R5: An accepted write with bit 13 set and bits 12:10 equal to 1 pulses `suspend_req` alone. This holds whatever `cfg_s4_type` is.
- R6: An accepted write with bit 13 set and a type from 2 to 7 pulses `disk_notify` and `poweroff_req` together if the type equals `cfg_s4_type`, and pulses nothing otherwise.
- R7: An accepted write with bit 13 clear pulses no request, whatever its type field holds.
- R8: `sci_en_set` sets bit 0 of the stored word on the next edge. Otherwise `sci_en_clr` clears it. Set wins over clear, and both override bit 0 of a write in the same cycle.
- R9: A synchronous active-low reset clears the stored word and all request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (8) | Byte address in the register window |
| acc_size | input | 2 | Access width code: 0 = 8-bit, 1 = 16-bit, 2 = 32-bit |
| acc_wdata | input | 16 | Write data, little-endian |
| acc_rdata | output | 16 | Read data, valid in the same cycle as the read |
| cfg_s4_type | input | 3 | Sleep-type value that selects suspend-to-disk |
| sci_en_set | input | 1 | Force bit 0 high |
| sci_en_clr | input | 1 | Force bit 0 low |
| poweroff_req | output | 1 | Power-off request pulse |
| suspend_req | output | 1 | Suspend-to-RAM request pulse |
| disk_notify | output | 1 | Suspend-to-disk notification pulse |

## Verification
The bench sweeps every sleep type against every `cfg_s4_type` value, with sleep-go both set and clear. This catches a decoder that lets a configured value of 0 or 1 take over the fixed types. It also catches one that fires on types 2 to 7 without a match, or one that acts when sleep-go is clear. Every write is followed by a read, which exposes a register that keeps bit 13. The cycle after each pulse is checked too, which exposes a pulse held longer than one cycle. Byte-wide, word-wide and wrongly addressed accesses are sent with sleep-go set, so a loose address or size decode shows up as a spurious pulse or a corrupted word. Finally, set and clear are driven together and against a same-cycle write, which catches reversed priority or a write that overrides them.

// File: rtl/sleepctl_pkg.sv
// Package: shared layout of the sleep control word and the request kinds.
// Assumes the field positions below are fixed by the software contract.
package sleepctl_pkg;
    localparam int REG_W      = 16;
    localparam int SLP_GO_BIT = 13;
    localparam int TYPE_LSB   = 10;
    localparam int TYPE_W     = 3;
    localparam int SCI_BIT    = 0;
    localparam logic [1:0] SIZE_HALF = 2'd1;
    localparam logic [TYPE_W-1:0] TYPE_OFF = 3'd0;
    localparam logic [TYPE_W-1:0] TYPE_RAM = 3'd1;

    typedef enum logic [1:0] {
        SLP_NONE = 2'd0,
        SLP_OFF  = 2'd1,
        SLP_RAM  = 2'd2,
        SLP_DISK = 2'd3
    } sleep_kind_e;
endpackage

// File: rtl/sleepctl_bus_decode.sv
// Module: access decoder. It qualifies accesses by address and width, and
// returns read data. Assumes reads complete in the same cycle.
module sleepctl_bus_decode #(
    parameter int ADDR_W     = 8,
    parameter int REG_OFFSET = 4
) (
    input  logic                               acc_valid,
    input  logic                               acc_write,
    input  logic [ADDR_W-1:0]                  acc_addr,
    input  logic [1:0]                         acc_size,
    input  logic [sleepctl_pkg::REG_W-1:0]     ctl_q,
    output logic                               wr_hit,
    output logic [sleepctl_pkg::REG_W-1:0]     acc_rdata
);
    import sleepctl_pkg::*;

    localparam logic [ADDR_W-1:0] OFFSET = ADDR_W'(REG_OFFSET);

    logic hit;
    logic rd_hit;

    // Accept only 16-bit accesses to the register offset.
    always_comb begin
        hit    = acc_valid && (acc_addr == OFFSET) && (acc_size == SIZE_HALF);
        wr_hit = hit && acc_write;
        rd_hit = hit && !acc_write;
    end

    // Return the stored word on an accepted read, zero otherwise.
    always_comb begin
        acc_rdata = rd_hit ? ctl_q : '0;
    end
endmodule

// File: rtl/sleepctl_reg.sv
// Module: storage for the control word. Sleep-go is dropped on every write,
// and the interrupt-enable bit can be forced by side inputs, with set
// winning. Assumes a synchronous active-low reset.
module sleepctl_reg (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_hit,
    input  logic [sleepctl_pkg::REG_W-1:0] wdata,
    input  logic                           sci_set,
    input  logic                           sci_clr,
    output logic [sleepctl_pkg::REG_W-1:0] ctl_q
);
    import sleepctl_pkg::*;

    localparam logic [REG_W-1:0] KEEP_MASK = ~(REG_W'(1) << SLP_GO_BIT);

    logic [REG_W-1:0] ctl_d;

    // Next word: apply the write first, then the enable overrides.
    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit) begin
            ctl_d = wdata & KEEP_MASK;
        end
        if (sci_set) begin
            ctl_d[SCI_BIT] = 1'b1;
        end else if (sci_clr) begin
            ctl_d[SCI_BIT] = 1'b0;
        end
    end

    // Register the word with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end
endmodule

// File: rtl/sleepctl_sleep_decode.sv
// Module: sleep-type decoder. It turns a write that carries sleep-go into
// one-cycle request pulses. Types 0 and 1 are fixed; the disk state is
// picked by a configured match that only types 2 to 7 can hit.
module sleepctl_sleep_decode (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                wr_hit,
    input  logic                                slp_go,
    input  logic [sleepctl_pkg::TYPE_W-1:0]     slp_type,
    input  logic [sleepctl_pkg::TYPE_W-1:0]     cfg_s4_type,
    output logic                                poweroff_req,
    output logic                                suspend_req,
    output logic                                disk_notify
);
    import sleepctl_pkg::*;

    sleep_kind_e kind;

    // Classify the write into a request kind.
    always_comb begin
        kind = SLP_NONE;
        if (wr_hit && slp_go) begin
            if (slp_type == TYPE_OFF) begin
                kind = SLP_OFF;
            end else if (slp_type == TYPE_RAM) begin
                kind = SLP_RAM;
            end else if (slp_type == cfg_s4_type) begin
                kind = SLP_DISK;
            end
        end
    end

    // Register the pulses; they fall back to zero on the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poweroff_req <= 1'b0;
            suspend_req  <= 1'b0;
            disk_notify  <= 1'b0;
        end else begin
            poweroff_req <= (kind == SLP_OFF) || (kind == SLP_DISK);
            suspend_req  <= (kind == SLP_RAM);
            disk_notify  <= (kind == SLP_DISK);
        end
    end
endmodule

// File: rtl/sleepctl_top.sv
// Module: sleep control register decoder top. It ties the access decoder,
// the word storage and the sleep-type decoder together.
module sleepctl_top #(
    parameter int ADDR_W     = 8,
    parameter int REG_OFFSET = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               acc_valid,
    input  logic                               acc_write,
    input  logic [ADDR_W-1:0]                  acc_addr,
    input  logic [1:0]                         acc_size,
    input  logic [sleepctl_pkg::REG_W-1:0]     acc_wdata,
    output logic [sleepctl_pkg::REG_W-1:0]     acc_rdata,
    input  logic [sleepctl_pkg::TYPE_W-1:0]    cfg_s4_type,
    input  logic                               sci_en_set,
    input  logic                               sci_en_clr,
    output logic                               poweroff_req,
    output logic                               suspend_req,
    output logic                               disk_notify
);
    import sleepctl_pkg::*;

    logic             wr_hit;
    logic [REG_W-1:0] ctl_q;

    sleepctl_bus_decode #(
        .ADDR_W     (ADDR_W),
        .REG_OFFSET (REG_OFFSET)
    ) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .acc_size  (acc_size),
        .ctl_q     (ctl_q),
        .wr_hit    (wr_hit),
        .acc_rdata (acc_rdata)
    );

    sleepctl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wdata   (acc_wdata),
        .sci_set (sci_en_set),
        .sci_clr (sci_en_clr),
        .ctl_q   (ctl_q)
    );

    sleepctl_sleep_decode u_slp (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_hit       (wr_hit),
        .slp_go       (acc_wdata[SLP_GO_BIT]),
        .slp_type     (acc_wdata[TYPE_LSB +: TYPE_W]),
        .cfg_s4_type  (cfg_s4_type),
        .poweroff_req (poweroff_req),
        .suspend_req  (suspend_req),
        .disk_notify  (disk_notify)
    );
endmodule

// File: rtl/sleepctl_chk.sv
// Module: assertion checker bound to the top. It watches the ports and the
// stored word.
module sleepctl_chk #(
    parameter int ADDR_W     = 8,
    parameter int REG_OFFSET = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_write,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [1:0]        acc_size,
    input logic [15:0]       acc_wdata,
    input logic [15:0]       acc_rdata,
    input logic              sci_en_set,
    input logic              sci_en_clr,
    input logic              poweroff_req,
    input logic              suspend_req,
    input logic              disk_notify,
    input logic [15:0]       ctl_q
);
    logic wr_ok;
    assign wr_ok = acc_valid && acc_write && (acc_addr == ADDR_W'(REG_OFFSET)) && (acc_size == 2'd1);

    AST_SLP_GO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !acc_rdata[13]); // R1
    AST_SLP_GO_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n) !ctl_q[13]); // R1
    AST_IGNORED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && !sci_en_set && !sci_en_clr) |=> $stable(ctl_q)); // R2
    AST_REQ_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (poweroff_req || suspend_req || disk_notify) |-> $past(wr_ok && acc_wdata[13])); // R3
    AST_OFF_SUS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({poweroff_req, suspend_req})); // R4
    AST_DISK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        disk_notify |-> (poweroff_req && !suspend_req)); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sci_en_set |=> ctl_q[0]); // R8
    AST_CLR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_en_clr && !sci_en_set) |=> !ctl_q[0]); // R8
endmodule

bind sleepctl_top sleepctl_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .acc_valid    (acc_valid),
    .acc_write    (acc_write),
    .acc_addr     (acc_addr),
    .acc_size     (acc_size),
    .acc_wdata    (acc_wdata),
    .acc_rdata    (acc_rdata),
    .sci_en_set   (sci_en_set),
    .sci_en_clr   (sci_en_clr),
    .poweroff_req (poweroff_req),
    .suspend_req  (suspend_req),
    .disk_notify  (disk_notify),
    .ctl_q        (ctl_q)
);

// File: tb/tb_sleepctl_top.sv
`timescale 1ns/1ps
module tb_sleepctl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic [15:0] acc_wdata = '0;
    logic [15:0] acc_rdata;
    logic [2:0]  cfg_s4_type = '0;
    logic        sci_en_set = 1'b0;
    logic        sci_en_clr = 1'b0;
    logic        poweroff_req, suspend_req, disk_notify;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sleepctl_top dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .cfg_s4_type(cfg_s4_type),
        .sci_en_set(sci_en_set), .sci_en_clr(sci_en_clr),
        .poweroff_req(poweroff_req), .suspend_req(suspend_req),
        .disk_notify(disk_notify)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Write, then return the pulses {off,sus,disk} in the next cycle and the one after.
    task automatic bus_write(input logic [7:0] a, input logic [1:0] sz, input logic [15:0] d,
                             output logic [2:0] p1, output logic [2:0] p2);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = a; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        p1 = {poweroff_req, suspend_req, disk_notify};
        acc_valid = 1'b0; acc_write = 1'b0; acc_wdata = '0;
        @(negedge clk);
        p2 = {poweroff_req, suspend_req, disk_notify};
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [1:0] sz, output logic [15:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_addr = a; acc_size = sz;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0]  p1, p2, ep;
        logic [15:0] rd, wd;
        repeat (3) @(negedge clk);
        bus_read(8'd4, 2'd1, rd);
        chk(rd == 16'h0, "R9 reset word", rd, 0);
        chk({poweroff_req, suspend_req, disk_notify} == 3'b0, "R9 reset pulses",
            {poweroff_req, suspend_req, disk_notify}, 0);
        @(negedge clk); rst_n = 1'b1;

        // Sweep every configured value, type and sleep-go setting.
        for (int s = 0; s < 8; s++) begin
            cfg_s4_type = 3'(s);
            for (int t = 0; t < 8; t++) begin
                for (int g = 0; g < 2; g++) begin
                    wd = 16'h4000 | 16'(g << 13) | 16'(t << 10) | 16'((s * 37 + t * 11 + g) & 10'h3FF);
                    if (g == 0) ep = 3'b000;
                    else if (t == 0) ep = 3'b100;
                    else if (t == 1) ep = 3'b010;
                    else if (t == s) ep = 3'b101;
                    else ep = 3'b000;
                    bus_write(8'd4, 2'd1, wd, p1, p2);
                    chk(p1 == ep, g == 0 ? "R7 no go no pulse" :
                        (t == 0 ? "R4 type0 off" : (t == 1 ? "R5 type1 suspend" : "R6 disk match")),
                        p1, ep);
                    chk(p2 == 3'b000, "R3 single cycle", p2, 0);
                    bus_read(8'd4, 2'd1, rd);
                    chk(rd == (wd & 16'hDFFF), "R1 stored without go", rd, wd & 16'hDFFF);
                end
            end
        end

        // Rejected accesses: wrong width or offset, with sleep-go and type 0.
        cfg_s4_type = 3'd5;
        bus_write(8'd4, 2'd1, 16'h0123, p1, p2);
        bus_write(8'd4, 2'd0, 16'h2000, p1, p2);
        chk(p1 == 3'b000, "R2 byte write ignored", p1, 0);
        bus_write(8'd4, 2'd2, 16'h2000, p1, p2);
        chk(p1 == 3'b000, "R2 word write ignored", p1, 0);
        bus_write(8'd6, 2'd1, 16'h2000, p1, p2);
        chk(p1 == 3'b000, "R2 offset write ignored", p1, 0);
        bus_read(8'd4, 2'd1, rd);
        chk(rd == 16'h0123, "R2 word unchanged", rd, 16'h0123);
        bus_read(8'd5, 2'd1, rd);
        chk(rd == 16'h0, "R2 bad offset read", rd, 0);
        bus_read(8'd4, 2'd0, rd);
        chk(rd == 16'h0, "R2 bad width read", rd, 0);

        // Enable-bit overrides.
        @(negedge clk); sci_en_set = 1'b1; @(negedge clk); sci_en_set = 1'b0;
        bus_read(8'd4, 2'd1, rd);
        chk(rd == 16'h0123, "R8 set", rd, 16'h0123);
        @(negedge clk); sci_en_clr = 1'b1; @(negedge clk); sci_en_clr = 1'b0;
        bus_read(8'd4, 2'd1, rd);
        chk(rd == 16'h0122, "R8 clear", rd, 16'h0122);
        @(negedge clk); sci_en_set = 1'b1; sci_en_clr = 1'b1;
        @(negedge clk); sci_en_set = 1'b0; sci_en_clr = 1'b0;
        bus_read(8'd4, 2'd1, rd);
        chk(rd == 16'h0123, "R8 set wins", rd, 16'h0123);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 8'd4; acc_size = 2'd1;
        acc_wdata = 16'h0F00; sci_en_set = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; sci_en_set = 1'b0;
        bus_read(8'd4, 2'd1, rd);
        chk(rd == 16'h0F01, "R8 set beats write", rd, 16'h0F01);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_wdata = 16'h0F01; sci_en_clr = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; sci_en_clr = 1'b0;
        bus_read(8'd4, 2'd1, rd);
        chk(rd == 16'h0F00, "R8 clear beats write", rd, 16'h0F00);

        // Reset in mid-run, with a pending pulse.
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_wdata = 16'h2000;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk({poweroff_req, suspend_req, disk_notify} == 3'b0, "R9 reset clears pulse",
            {poweroff_req, suspend_req, disk_notify}, 0);
        bus_read(8'd4, 2'd1, rd);
        chk(rd == 16'h0, "R9 reset clears word", rd, 0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule